// File: doc/BRIEF.md
# Programmed-I/O Configuration Request Engine

This block lets software issue one PCIe configuration read or write at a time through a small memory-mapped register set. Software fills in the request type, a 64-bit target address, the write data and a byte-enable mask. It then launches the request by writing 1 to the start register. The engine presents the request to a transaction-layer completer interface and holds it there until the completer answers. It then records the completion code, an error flag and a non-posted marker. For a successful read it also keeps the returned data.

The handshake works like this. Start stays set for as long as the request is outstanding, and it drops on the same clock edge that the interrupt-status bit rises. The interrupt-status bit stays set until software writes 1 to it. A transfer is finished when start reads 0 and interrupt status reads non-zero. The usual launch sequence is: write 0 to start, write 1 to interrupt status, then write 1 to start.

Top module: `cfg_pio_engine`

## Requirements
- R1: After synchronous reset every register reads 0, and req_valid and irq are 0. Offsets that are not listed in R2 to R8, and addresses with any bit set above bit 5, read 0.
- R2: Control register (offset 0x00). Bits 3:0 are the request type and bit 24 is the address-window bypass flag. Both read back exactly as written, and every other bit reads 0. Type values: 0x8 config read type 0, 0x9 config read type 1, 0xA config write type 0, 0xB config write type 1.
- R3: These registers read back as written: address low (0x08), address high (0x0C) and write data (0x10). The write-strobe register (0x14) keeps only bits 3:0. While a request is outstanding, req_addr = {address high, address low}, and req_type, req_wdata and req_strb carry the programmed values.
- R4: Writing a value with bit 0 = 1 to start (0x1C) while idle launches a request. On the next cycle start reads 1 and req_valid is 1. req_valid rises only after such a write.
- R5: req_valid and start stay at 1 until a cycle with cpl_valid = 1. After that cycle start reads 0, req_valid is 0 and interrupt status (0x20) reads 1.
- R6: At completion the status register (0x04) is loaded as follows. Bits 9:7 take cpl_code (0 success, 1 unsupported request, 2 configuration retry, 4 completer abort). Bit 11 takes cpl_err. Bit 10 is 1 when the type was one of 0x8 to 0xB. All other bits read 0.
- R7: The read-data register (0x18) is loaded with cpl_data only when all of these hold: the completing request's type is 0x8 or 0x9, cpl_code is 0 and cpl_err is 0. Otherwise it keeps its old value.
- R8: Writing 1 in bit 0 of interrupt status clears it, and writing 0 has no effect. If a clear and a completion fall in the same cycle, interrupt status ends at 1. irq equals interrupt status.
- R9: While a request is outstanding, writes to control, address low, address high, write data, write strobe and start are ignored, so the request fields and the readback stay unchanged.
- R10: cpl_valid while no request is outstanding is ignored: status, read data and interrupt status are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe for this cycle |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational readback of the addressed register |
| req_valid | output | 1 | Request outstanding to the completer |
| req_type | output | 4 | Request type code |
| req_addr | output | 64 | Request address {high, low} |
| req_wdata | output | 32 | Write data for write requests |
| req_strb | output | 4 | Byte enables |
| req_win_bypass | output | 1 | Address-window bypass flag from control bit 24 |
| cpl_valid | input | 1 | Completer response, one cycle |
| cpl_code | input | 3 | Completion code |
| cpl_err | input | 1 | Completion error flag |
| cpl_data | input | 32 | Completion read data |
| irq | output | 1 | Interrupt status bit |

## Verification
The assertions run on every cycle and check the request handshake:
- req_valid rises only after a start write.
- req_valid stays high until a completion arrives, and drops as irq rises after one.
- The request fields stay stable while a request is outstanding.
- irq cannot rise without a request.

The other behaviours can only be shown by the bench's scenarios. These are the contents of the status and read-data registers after each completion code, the rule that read data is captured only on a successful read, the control field masking, the ignored writes while busy, and the set-over-clear priority of interrupt status.

// File: rtl/cfg_pio_pkg.sv
// Package: shared constants for the configuration request engine.
// Assumes a 32-bit register bus with byte offsets decoded in the low 6 bits.
package cfg_pio_pkg;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 6;
    localparam int NREG   = 9;

    localparam logic [OFF_W-1:0] OFF_CTRL  = 6'h00;
    localparam logic [OFF_W-1:0] OFF_STAT  = 6'h04;
    localparam logic [OFF_W-1:0] OFF_ALO   = 6'h08;
    localparam logic [OFF_W-1:0] OFF_AHI   = 6'h0C;
    localparam logic [OFF_W-1:0] OFF_WDAT  = 6'h10;
    localparam logic [OFF_W-1:0] OFF_STRB  = 6'h14;
    localparam logic [OFF_W-1:0] OFF_RDAT  = 6'h18;
    localparam logic [OFF_W-1:0] OFF_START = 6'h1C;
    localparam logic [OFF_W-1:0] OFF_ISR   = 6'h20;

    localparam int IX_CTRL = 0, IX_STAT = 1, IX_ALO = 2, IX_AHI = 3, IX_WDAT = 4,
                   IX_STRB = 5, IX_RDAT = 6, IX_START = 7, IX_ISR = 8;

    localparam int WIN_BIT = 24;

    // Latched completion record
    typedef struct packed {
        logic       err;
        logic       nonposted;
        logic [2:0] code;
    } cpl_stat_t;

    // Config request types occupy 0x8..0xB
    function automatic logic is_cfg(input logic [3:0] t);
        return t[3:2] == 2'b10;
    endfunction

    // Config reads are 0x8 and 0x9
    function automatic logic is_cfg_read(input logic [3:0] t);
        return (t[3:2] == 2'b10) && !t[1];
    endfunction
endpackage

// File: rtl/cfg_pio_seq.sv
// Module: request sequencer. Holds the busy (start) flag from launch until
// the completer answers; produces a one-cycle done indication.
// Assumes launch_req may arrive at any time; it is ignored while busy.
module cfg_pio_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_req,
    input  logic cpl_valid,
    output logic busy,
    output logic done
);
    // Completion is only meaningful when a request is outstanding
    always_comb done = busy && cpl_valid;

    // Busy flag: set by launch, cleared by completion
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (!busy && launch_req)
            busy <= 1'b1;
        else if (done)
            busy <= 1'b0;
    end
endmodule

// File: rtl/cfg_pio_regs.sv
// Module: software-visible register file. Decodes the bus, stores request
// fields, latches completion status/read data and the interrupt bit.
// Assumes ADDR_W > OFF_W; configuration writes are blocked while busy.
module cfg_pio_regs
    import cfg_pio_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [2:0]        cpl_code,
    input  logic              cpl_err,
    input  logic [DATA_W-1:0] cpl_data,
    output logic              launch_req,
    output logic [3:0]        ctrl_type,
    output logic              win_bypass,
    output logic [DATA_W-1:0] addr_lo,
    output logic [DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0] wr_data,
    output logic [3:0]        wr_strb,
    output logic              isr
);
    localparam logic [OFF_W-1:0] OFFS [NREG] = '{OFF_CTRL, OFF_STAT, OFF_ALO, OFF_AHI,
        OFF_WDAT, OFF_STRB, OFF_RDAT, OFF_START, OFF_ISR};

    logic [NREG-1:0] sel;
    logic            in_win;
    logic            cfg_we;
    cpl_stat_t       stat_q;
    logic [DATA_W-1:0] rd_data;

    // Address falls inside this block's register window
    always_comb in_win = (bus_addr[ADDR_W-1:OFF_W] == '0);

    // One select line per register
    generate
        for (genvar i = 0; i < NREG; i++) begin : g_dec
            assign sel[i] = in_win && (bus_addr[OFF_W-1:0] == OFFS[i]);
        end
    endgenerate

    // Request fields are writable only when idle
    always_comb cfg_we = bus_wr && !busy;
    always_comb launch_req = cfg_we && sel[IX_START] && bus_wdata[0];

    // Request field storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_type  <= '0;
            win_bypass <= 1'b0;
            addr_lo    <= '0;
            addr_hi    <= '0;
            wr_data    <= '0;
            wr_strb    <= '0;
        end else if (cfg_we) begin
            if (sel[IX_CTRL]) begin
                ctrl_type  <= bus_wdata[3:0];
                win_bypass <= bus_wdata[WIN_BIT];
            end
            if (sel[IX_ALO])  addr_lo <= bus_wdata;
            if (sel[IX_AHI])  addr_hi <= bus_wdata;
            if (sel[IX_WDAT]) wr_data <= bus_wdata;
            if (sel[IX_STRB]) wr_strb <= bus_wdata[3:0];
        end
    end

    // Completion record and read data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q  <= '0;
            rd_data <= '0;
        end else if (done) begin
            stat_q <= '{err: cpl_err, nonposted: is_cfg(ctrl_type), code: cpl_code};
            if (is_cfg_read(ctrl_type) && (cpl_code == 3'd0) && !cpl_err)
                rd_data <= cpl_data;
        end
    end

    // Interrupt bit: completion sets, write-one clears, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            isr <= 1'b0;
        else if (done)
            isr <= 1'b1;
        else if (bus_wr && sel[IX_ISR] && bus_wdata[0])
            isr <= 1'b0;
    end

    // Readback multiplexer
    always_comb begin
        bus_rdata = '0;
        if (sel[IX_CTRL])  bus_rdata = {7'b0, win_bypass, 20'b0, ctrl_type};
        if (sel[IX_STAT])  bus_rdata = {20'b0, stat_q, 7'b0};
        if (sel[IX_ALO])   bus_rdata = addr_lo;
        if (sel[IX_AHI])   bus_rdata = addr_hi;
        if (sel[IX_WDAT])  bus_rdata = wr_data;
        if (sel[IX_STRB])  bus_rdata = {28'b0, wr_strb};
        if (sel[IX_RDAT])  bus_rdata = rd_data;
        if (sel[IX_START]) bus_rdata = {31'b0, busy};
        if (sel[IX_ISR])   bus_rdata = {31'b0, isr};
    end
endmodule

// File: rtl/cfg_pio_engine.sv
// Module: top of the programmed-I/O configuration request engine. Joins the
// register file and the sequencer and drives the completer-side request.
// Assumes the completer answers each request with a single cpl_valid pulse.
module cfg_pio_engine
    import cfg_pio_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              req_valid,
    output logic [3:0]        req_type,
    output logic [63:0]       req_addr,
    output logic [31:0]       req_wdata,
    output logic [3:0]        req_strb,
    output logic              req_win_bypass,
    input  logic              cpl_valid,
    input  logic [2:0]        cpl_code,
    input  logic              cpl_err,
    input  logic [31:0]       cpl_data,
    output logic              irq
);
    logic busy, done, launch_req;
    logic [31:0] addr_lo, addr_hi;

    cfg_pio_seq u_seq (
        .clk(clk), .rst_n(rst_n), .launch_req(launch_req),
        .cpl_valid(cpl_valid), .busy(busy), .done(done)
    );

    cfg_pio_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .done(done),
        .cpl_code(cpl_code), .cpl_err(cpl_err), .cpl_data(cpl_data),
        .launch_req(launch_req), .ctrl_type(req_type), .win_bypass(req_win_bypass),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .wr_data(req_wdata),
        .wr_strb(req_strb), .isr(irq)
    );

    // Request outputs follow the busy flag and stored fields
    always_comb begin
        req_valid = busy;
        req_addr  = {addr_hi, addr_lo};
    end
endmodule

// File: rtl/cfg_pio_checker.sv
// Module: protocol checker for cfg_pio_engine, attached by bind.
// Assumes it sees the top-level ports only.
module cfg_pio_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              req_valid,
    input logic [3:0]        req_type,
    input logic [63:0]       req_addr,
    input logic [31:0]       req_wdata,
    input logic [3:0]        req_strb,
    input logic              cpl_valid,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] START_ADDR = ADDR_W'(8'h1C);

    AST_LAUNCH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(bus_wr && bus_addr == START_ADDR && bus_wdata[0])); // R4
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !cpl_valid |=> req_valid); // R5
    AST_CPL_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cpl_valid |=> !req_valid && irq); // R5
    AST_REQ_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !cpl_valid |=> $stable(req_type) && $stable(req_addr)
                                    && $stable(req_wdata) && $stable(req_strb)); // R9
    AST_NO_IRQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid && !irq |=> !irq); // R10
endmodule

bind cfg_pio_engine cfg_pio_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
    .cpl_valid(cpl_valid), .irq(irq)
);

// File: tb/cfg_pio_engine_bench.sv
`timescale 1ns/1ps
module cfg_pio_engine_bench;
    localparam int AW = 12;
    localparam logic [AW-1:0] A_CTRL = 12'h000, A_STAT = 12'h004, A_ALO = 12'h008,
        A_AHI = 12'h00C, A_WDAT = 12'h010, A_STRB = 12'h014, A_RDAT = 12'h018,
        A_START = 12'h01C, A_ISR = 12'h020;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic req_valid, req_win_bypass, irq;
    logic [3:0] req_type, req_strb;
    logic [63:0] req_addr;
    logic [31:0] req_wdata;
    logic cpl_valid = 1'b0, cpl_err = 1'b0;
    logic [2:0] cpl_code = '0;
    logic [31:0] cpl_data = '0;

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cfg_pio_engine #(.ADDR_W(AW)) u_cfg_pio_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
        .req_type(req_type), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_strb(req_strb), .req_win_bypass(req_win_bypass), .cpl_valid(cpl_valid),
        .cpl_code(cpl_code), .cpl_err(cpl_err), .cpl_data(cpl_data), .irq(irq)
    );

    typedef struct packed {
        logic [3:0]  typ;
        logic [31:0] alo;
        logic [31:0] wd;
        logic [3:0]  st;
        logic [2:0]  code;
        logic        err;
        logic [31:0] cd;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{4'h8, 32'h0010_0004, 32'h0000_0000, 4'hF, 3'd0, 1'b0, 32'h1234_5678},
        '{4'hA, 32'h0020_0010, 32'hDEAD_BEEF, 4'h3, 3'd0, 1'b0, 32'h5A5A_5A5A},
        '{4'h9, 32'h0130_8008, 32'h0000_0000, 4'hF, 3'd1, 1'b0, 32'hAAAA_5555},
        '{4'h9, 32'h0130_800C, 32'h0000_0000, 4'hF, 3'd0, 1'b1, 32'h0BAD_0BAD},
        '{4'hB, 32'h0240_0040, 32'h0000_00C0, 4'h1, 3'd2, 1'b0, 32'h1111_1111},
        '{4'h8, 32'h0000_0100, 32'h0000_0000, 4'hF, 3'd4, 1'b0, 32'h2222_2222},
        '{4'h9, 32'h0150_0000, 32'h0000_0000, 4'hF, 3'd0, 1'b0, 32'hCAFE_F00D}
    };

    // Compare and count one result
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One register write, committed at the posedge between two negedges
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Combinational register read away from the edge
    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    // Completer stub response, one cycle
    task automatic respond(input logic [2:0] c, input logic e, input logic [31:0] d);
        cpl_valid = 1'b1; cpl_code = c; cpl_err = e; cpl_data = d;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    // Software launch sequence
    task automatic launch();
        wr(A_START, 32'h0);
        wr(A_ISR, 32'h1);
        wr(A_START, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp_rd;
        logic [31:0] exp_st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
        rd(A_STAT, v);  chk("R1 stat", v, 0);
        rd(A_RDAT, v);  chk("R1 rdat", v, 0);
        rd(A_START, v); chk("R1 start", v, 0);
        rd(A_ISR, v);   chk("R1 isr", v, 0);
        chk("R1 req_valid", req_valid, 0);
        chk("R1 irq", irq, 0);

        // R2: control masking and window bit readback
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); chk("R2 ctrl mask", v, 32'h0100_000F);
        wr(A_CTRL, 32'h0000_0009);
        rd(A_CTRL, v); chk("R2 ctrl win clear", v, 32'h0000_0009);
        chk("R2 bypass out", req_win_bypass, 0);

        // R3: address/data/strobe readback
        wr(A_AHI, 32'hFFFF_FFFF);  rd(A_AHI, v);  chk("R3 ahi", v, 32'hFFFF_FFFF);
        wr(A_AHI, 32'h0);
        wr(A_STRB, 32'hFFFF_FFF6); rd(A_STRB, v); chk("R3 strb", v, 32'h6);
        wr(A_WDAT, 32'h0F0F_1234); rd(A_WDAT, v); chk("R3 wdat", v, 32'h0F0F_1234);
        // R1: unmapped offset and out-of-window address read 0
        rd(12'h024, v); chk("R1 unmapped", v, 0);
        rd(12'h110, v); chk("R1 outside window", v, 0);

        // R10: completion while idle ignored
        respond(3'd4, 1'b1, 32'h7777_7777);
        rd(A_STAT, v); chk("R10 stat", v, 0);
        rd(A_ISR, v);  chk("R10 isr", v, 0);
        rd(A_RDAT, v); chk("R10 rdat", v, 0);

        // Table walk: R4 R5 R6 R7 R3
        exp_rd = 32'h0;
        for (int i = 0; i < NV; i++) begin
            wr(A_CTRL, {7'b0, 1'b1, 20'b0, VECS[i].typ});
            wr(A_ALO, VECS[i].alo);
            wr(A_AHI, 32'h0000_0000 + i);
            wr(A_WDAT, VECS[i].wd);
            wr(A_STRB, {28'b0, VECS[i].st});
            launch();
            rd(A_START, v); chk("R4 start set", v, 1);
            chk("R4 req_valid", req_valid, 1);
            chk("R3 req_addr", req_addr, {32'h0000_0000 + i, VECS[i].alo});
            chk("R3 req_type", req_type, VECS[i].typ);
            chk("R3 req_wdata", req_wdata, VECS[i].wd);
            chk("R3 req_strb", req_strb, VECS[i].st);
            chk("R2 bypass", req_win_bypass, 1);
            repeat (i + 1) @(negedge clk);
            chk("R5 still pending", req_valid, 1);
            respond(VECS[i].code, VECS[i].err, VECS[i].cd);
            rd(A_START, v); chk("R5 start cleared", v, 0);
            rd(A_ISR, v);   chk("R5 isr set", v, 1);
            chk("R5 req_valid low", req_valid, 0);
            exp_st = {20'b0, VECS[i].err, 1'b1, VECS[i].code, 7'b0};
            rd(A_STAT, v);  chk("R6 status", v, exp_st);
            if (VECS[i].typ[1] == 1'b0 && VECS[i].code == 3'd0 && !VECS[i].err)
                exp_rd = VECS[i].cd;
            rd(A_RDAT, v);  chk("R7 rdata", v, exp_rd);
        end

        // R8: write 0 keeps isr, write 1 clears
        wr(A_ISR, 32'h0); rd(A_ISR, v); chk("R8 isr write0", v, 1);
        chk("R8 irq follows", irq, 1);
        wr(A_ISR, 32'h1); rd(A_ISR, v); chk("R8 isr clear", v, 0);
        chk("R8 irq low", irq, 0);

        // R9: writes while busy ignored
        wr(A_CTRL, 32'h0000_0008);
        wr(A_ALO, 32'h0000_0abc);
        wr(A_AHI, 32'h0);
        launch();
        wr(A_CTRL, 32'h0100_000B);
        wr(A_ALO, 32'h5555_0000);
        wr(A_STRB, 32'h2);
        wr(A_START, 32'h0);
        rd(A_CTRL, v);  chk("R9 ctrl kept", v, 32'h0000_0008);
        rd(A_ALO, v);   chk("R9 alo kept", v, 32'h0000_0ABC);
        rd(A_STRB, v);  chk("R9 strb kept", v, VECS[NV-1].st);
        rd(A_START, v); chk("R9 start kept", v, 1);
        chk("R9 req_addr", req_addr, 64'h0000_0ABC);

        // R8: clear and completion in same cycle, set wins
        bus_wr = 1'b1; bus_addr = A_ISR; bus_wdata = 32'h1;
        cpl_valid = 1'b1; cpl_code = 3'd0; cpl_err = 1'b0; cpl_data = 32'h0102_0304;
        @(negedge clk);
        bus_wr = 1'b0; cpl_valid = 1'b0;
        rd(A_ISR, v);  chk("R8 set wins", v, 1);
        rd(A_RDAT, v); chk("R7 final read", v, 32'h0102_0304);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule